// File: doc/BRIEF.md
# Byte-Wide Register Loader with Auto-Addressing

This block is the programming port of a video timing generator. An 8-bit data bus, a load strobe, an address/data select and a byte select write a file of nineteen 12-bit configuration registers. Each register receives its low eight bits first and its upper four bits second. An address may be given before every register (manual mode). Alternatively, one start address is given and the port then steps through the registers by itself (auto mode). In auto mode, after the last register the port returns to the start address that was loaded.

The same address space holds special entries. A restart vector stops the timing engine and re-arms its counters when it is left. A clear vector zeroes the whole register file. A scan address shifts one register, or one of three external counter values, out on a single serial pin, least significant bit first. While a special entry is selected, a freeze output tells the timing engine to ignore its clock. The load strobe is asynchronous to the system clock and is synchronised inside the block. The controls and the data must stay steady across each strobe edge until that edge has been taken.

Top module: `vsg_prog_port`

## Requirements
- R1: After reset, every register reads 0, `restart_o` and `scan_o` are 0, and `freeze_o` is 1 because status bit 10 (clock enable, register 0) is 0.
- R2: A load with `sel_data_i`=0 takes the address from `din_i[5:0]`. With `sel_data_i`=1 and `sel_hi_i`=0, `din_i[7:0]` is written to bits 7:0 of the addressed register. With `sel_hi_i`=1, `din_i[3:0]` is written to bits 11:8 and `din_i[7:4]` is ignored.
- R3: `sel_data_i` and `sel_hi_i` are taken at the falling edge of `load_i`. The write or address load happens at the rising edge. Registers change only at a rising edge of the load.
- R4: A falling edge with `sel_data_i`=0 and `sel_hi_i`=1 enters auto mode, and the address advances by one after each high-byte write. A falling edge with both low returns to manual mode, where the address does not advance.
- R5: In auto mode the step after register 18 goes back to the loaded start address. A start address of 18 keeps writing register 18.
- R6: Addresses 19–21, 24–31 and 56–63 select no register, and data loads there change nothing. At most one register changes per load.
- R7: Address 22 or 54 (restart) raises `freeze_o` and keeps the registers. Loading a non-vector address afterwards gives exactly one `restart_o` cycle, and no other address change gives one.
- R8: Address 23 or 55 (clear) zeroes all nineteen registers and raises `freeze_o`.
- R9: In auto mode, a vector address never advances, and data loads made while it is selected write nothing.
- R10: Address 32+k (k = 0..18) raises `freeze_o`. `scan_o` shows bit 0 of register k in the cycle after the load takes effect, then one further bit on each clock. After bit 11, the MSB repeats.
- R11: Address 51+j (j = 0..2) scans `cnt_scan_i[12j+11:12j]` in the same way.
- R12: `freeze_o` is 1 whenever status bit 10 is 0 or a vector or scan address is selected. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Asynchronous load strobe, idle high |
| sel_data_i | input | 1 | 0 = address cycle, 1 = data cycle |
| sel_hi_i | input | 1 | 0 = low byte, 1 = high nibble; with address cycle, 1 = auto mode |
| din_i | input | 8 | Programming data bus |
| cnt_scan_i | input | 36 | Three 12-bit timing counter values for scan |
| regs_o | output | 228 | Register file, register k at bits 12k+11:12k |
| freeze_o | output | 1 | Timing engine must ignore its clock |
| restart_o | output | 1 | One-cycle counter restart request |
| scan_o | output | 1 | Serial scan output |

## Verification
Two functions can act in one load: the auto-increment step and the vector check. The bench provokes this by loading a restart vector as the start address in auto mode and then issuing low- and high-byte loads. It then checks that the address stays on the vector, that no register changes, and that freeze stays high. A second collision is between the restart pulse and the loading of a new address. The bench judges it by sampling `restart_o` in the cycle the new address takes effect and again one cycle later. It also checks that leaving a scan address gives no pulse.

// File: rtl/vsg_pkg.sv
// Shared constants and address classification for the register loader.
// Assumes a 6-bit address space; special entries are fixed by behaviour.
package vsg_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_RESTART_LO = 6'd22;
    localparam logic [ADDR_W-1:0] A_RESTART_HI = 6'd54;
    localparam logic [ADDR_W-1:0] A_CLEAR_LO   = 6'd23;
    localparam logic [ADDR_W-1:0] A_CLEAR_HI   = 6'd55;
    localparam logic [ADDR_W-1:0] SCAN_BASE    = 6'd32;
    localparam logic [ADDR_W-1:0] CNT_BASE     = 6'd51;

    typedef enum logic [2:0] {
        K_REG,
        K_RESTART,
        K_CLEAR,
        K_SCAN_REG,
        K_SCAN_CNT,
        K_NONE
    } addr_kind_e;

    // Sorts an address into its kind given the register and counter counts.
    function automatic addr_kind_e classify(input logic [ADDR_W-1:0] a,
                                            input logic [ADDR_W-1:0] nregs,
                                            input logic [ADDR_W-1:0] ncnt);
        logic [ADDR_W:0] ax;
        ax = {1'b0, a};
        if (a == A_RESTART_LO || a == A_RESTART_HI)
            return K_RESTART;
        if (a == A_CLEAR_LO || a == A_CLEAR_HI)
            return K_CLEAR;
        if (a < nregs)
            return K_REG;
        if (ax >= {1'b0, SCAN_BASE} && ax < ({1'b0, SCAN_BASE} + {1'b0, nregs}))
            return K_SCAN_REG;
        if (ax >= {1'b0, CNT_BASE} && ax < ({1'b0, CNT_BASE} + {1'b0, ncnt}))
            return K_SCAN_CNT;
        return K_NONE;
    endfunction

    // True for kinds that stop the timing engine.
    function automatic logic kind_halts(input addr_kind_e k);
        return (k == K_RESTART) || (k == K_CLEAR) || (k == K_SCAN_REG) || (k == K_SCAN_CNT);
    endfunction
endpackage

// File: rtl/vsg_load_sync.sv
// Brings the asynchronous strobe, selects and data bus into the clock domain
// and flags strobe edges. Assumes selects and data are steady around each
// strobe edge until that edge is seen here.
module vsg_load_sync #(
    parameter int STAGES = 2,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          sel_data_i,
    input  logic          sel_hi_i,
    input  logic [DW-1:0] din_i,
    output logic          rise_o,
    output logic          fall_o,
    output logic          sel_data_o,
    output logic          sel_hi_o,
    output logic [DW-1:0] din_o
);
    localparam int BW = DW + 3;

    logic [STAGES-1:0][BW-1:0] chain_q;
    logic                      load_prev_q;
    logic [BW-1:0]             last;

    // Shift chain; strobe resets to its idle high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++)
                chain_q[s] <= {1'b1, {(BW-1){1'b0}}};
        end else begin
            chain_q[0] <= {load_i, sel_data_i, sel_hi_i, din_i};
            for (int s = 1; s < STAGES; s++)
                chain_q[s] <= chain_q[s-1];
        end
    end

    // Remember the previous synchronised strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) load_prev_q <= 1'b1;
        else        load_prev_q <= last[BW-1];
    end

    assign last       = chain_q[STAGES-1];
    assign rise_o     = last[BW-1] & ~load_prev_q;
    assign fall_o     = ~last[BW-1] & load_prev_q;
    assign sel_data_o = last[BW-2];
    assign sel_hi_o   = last[BW-3];
    assign din_o      = last[DW-1:0];
endmodule

// File: rtl/vsg_addr_ctl.sv
// Address register, auto-increment counter and special-address decode.
// Assumes strobe edges come as single-cycle pulses from the synchroniser.
module vsg_addr_ctl
    import vsg_pkg::*;
#(
    parameter int NREGS = 19,
    parameter int NCNT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              sel_data_i,
    input  logic              sel_hi_i,
    input  logic [ADDR_W-1:0] new_addr_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic              wr_en_o,
    output logic              wr_hi_o,
    output logic              clr_all_o,
    output logic              scan_ld_o,
    output logic              scan_cnt_o,
    output logic [ADDR_W-1:0] scan_idx_o,
    output logic              scan_run_o,
    output logic              halt_o,
    output logic              restart_o
);
    localparam logic [ADDR_W-1:0] NREGS_A = ADDR_W'(NREGS);
    localparam logic [ADDR_W-1:0] NCNT_A  = ADDR_W'(NCNT);
    localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(NREGS - 1);

    logic              cap_data_q, cap_hi_q, auto_q, restart_q;
    logic [ADDR_W-1:0] addr_q, start_q;
    addr_kind_e        kind_cur, kind_new;
    logic              addr_ph, data_ph;

    // Decode the current and incoming address and the phase of this edge.
    always_comb begin
        kind_cur = classify(addr_q, NREGS_A, NCNT_A);
        kind_new = classify(new_addr_i, NREGS_A, NCNT_A);
        addr_ph  = rise_i & ~cap_data_q;
        data_ph  = rise_i &  cap_data_q;
    end

    // Capture cycle type and auto-mode choice on the strobe falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_data_q <= 1'b0;
            cap_hi_q   <= 1'b0;
            auto_q     <= 1'b0;
        end else if (fall_i) begin
            cap_data_q <= sel_data_i;
            cap_hi_q   <= sel_hi_i;
            if (!sel_data_i) auto_q <= sel_hi_i;
        end
    end

    // Load the address or step it in auto mode on the strobe rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            start_q <= '0;
        end else if (addr_ph) begin
            addr_q  <= new_addr_i;
            start_q <= new_addr_i;
        end else if (data_ph && auto_q && cap_hi_q && kind_cur == K_REG) begin
            addr_q <= (addr_q == LAST_A) ? start_q : addr_q + 1'b1;
        end
    end

    // One-cycle restart request when a restart vector is left.
    always_ff @(posedge clk) begin
        if (!rst_n) restart_q <= 1'b0;
        else        restart_q <= addr_ph && kind_cur == K_RESTART &&
                                 kind_new != K_RESTART && kind_new != K_CLEAR;
    end

    assign cur_addr_o = addr_q;
    assign wr_en_o    = data_ph && kind_cur == K_REG;
    assign wr_hi_o    = cap_hi_q;
    assign clr_all_o  = addr_ph && kind_new == K_CLEAR;
    assign scan_ld_o  = addr_ph && (kind_new == K_SCAN_REG || kind_new == K_SCAN_CNT);
    assign scan_cnt_o = kind_new == K_SCAN_CNT;
    assign scan_idx_o = (kind_new == K_SCAN_CNT) ? new_addr_i - CNT_BASE
                                                 : new_addr_i - SCAN_BASE;
    assign scan_run_o = kind_cur == K_SCAN_REG || kind_cur == K_SCAN_CNT;
    assign halt_o     = kind_halts(kind_cur);
    assign restart_o  = restart_q;
endmodule

// File: rtl/vsg_reg_file.sv
// Nineteen-entry configuration register file, written a byte at a time.
// Assumes at most one write enable per cycle; clear wins over writes.
module vsg_reg_file
    import vsg_pkg::*;
#(
    parameter int NREGS  = 19,
    parameter int REG_W  = 12,
    parameter int BYTE_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic                   wr_hi_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    input  logic [BYTE_W-1:0]      din_i,
    input  logic                   clr_i,
    output logic [NREGS*REG_W-1:0] regs_o
);
    localparam int HI_W = REG_W - BYTE_W;

    for (genvar k = 0; k < NREGS; k++) begin : g_reg
        logic [REG_W-1:0] r_q;

        // Hold one register; write a byte or nibble when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                r_q <= '0;
            end else if (wr_en_i && wr_addr_i == ADDR_W'(k)) begin
                if (wr_hi_i) r_q[REG_W-1:BYTE_W] <= din_i[HI_W-1:0];
                else         r_q[BYTE_W-1:0]     <= din_i;
            end
        end

        assign regs_o[k*REG_W +: REG_W] = r_q;
    end
endmodule

// File: rtl/vsg_scan_shift.sv
// Serial readout: loads a register or counter value and shifts it out LSB
// first, one bit per clock, repeating the MSB once the word is exhausted.
module vsg_scan_shift
    import vsg_pkg::*;
#(
    parameter int NREGS = 19,
    parameter int NCNT  = 3,
    parameter int REG_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld_i,
    input  logic                   use_cnt_i,
    input  logic [ADDR_W-1:0]      idx_i,
    input  logic                   run_i,
    input  logic [NREGS*REG_W-1:0] regs_i,
    input  logic [NCNT*REG_W-1:0]  cnt_i,
    output logic                   scan_o
);
    logic [REG_W-1:0] src, sh_q;

    // Pick the word selected by the incoming scan address.
    always_comb begin
        src = '0;
        if (use_cnt_i) begin
            for (int j = 0; j < NCNT; j++)
                if (idx_i == ADDR_W'(j)) src = cnt_i[j*REG_W +: REG_W];
        end else begin
            for (int k = 0; k < NREGS; k++)
                if (idx_i == ADDR_W'(k)) src = regs_i[k*REG_W +: REG_W];
        end
    end

    // Load on a new scan address, else shift right with MSB fill.
    always_ff @(posedge clk) begin
        if (!rst_n)     sh_q <= '0;
        else if (ld_i)  sh_q <= src;
        else if (run_i) sh_q <= {sh_q[REG_W-1], sh_q[REG_W-1:1]};
    end

    assign scan_o = sh_q[0];
endmodule

// File: rtl/vsg_prog_port.sv
// Top of the programming port: synchroniser, address control, register
// file and scan shifter. Freeze combines special addresses with the
// clock-enable bit of the status register.
module vsg_prog_port
    import vsg_pkg::*;
#(
    parameter int NREGS      = 19,
    parameter int NCNT       = 3,
    parameter int REG_W      = 12,
    parameter int BYTE_W     = 8,
    parameter int SYNC_STG   = 2,
    parameter int CLK_EN_BIT = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic                   sel_data_i,
    input  logic                   sel_hi_i,
    input  logic [BYTE_W-1:0]      din_i,
    input  logic [NCNT*REG_W-1:0]  cnt_scan_i,
    output logic [NREGS*REG_W-1:0] regs_o,
    output logic                   freeze_o,
    output logic                   restart_o,
    output logic                   scan_o
);
    logic              load_rise, load_fall, sd_s, sh_s;
    logic [BYTE_W-1:0] din_s;
    logic [ADDR_W-1:0] cur_addr, scan_idx;
    logic              wr_en, wr_hi, clr_all, scan_ld, scan_cnt, scan_run, halt;

    vsg_load_sync #(.STAGES(SYNC_STG), .DW(BYTE_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .sel_data_i(sel_data_i),
        .sel_hi_i(sel_hi_i), .din_i(din_i), .rise_o(load_rise), .fall_o(load_fall),
        .sel_data_o(sd_s), .sel_hi_o(sh_s), .din_o(din_s)
    );

    vsg_addr_ctl #(.NREGS(NREGS), .NCNT(NCNT)) u_addr (
        .clk(clk), .rst_n(rst_n), .rise_i(load_rise), .fall_i(load_fall),
        .sel_data_i(sd_s), .sel_hi_i(sh_s), .new_addr_i(din_s[ADDR_W-1:0]),
        .cur_addr_o(cur_addr), .wr_en_o(wr_en), .wr_hi_o(wr_hi),
        .clr_all_o(clr_all), .scan_ld_o(scan_ld), .scan_cnt_o(scan_cnt),
        .scan_idx_o(scan_idx), .scan_run_o(scan_run), .halt_o(halt),
        .restart_o(restart_o)
    );

    vsg_reg_file #(.NREGS(NREGS), .REG_W(REG_W), .BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_hi_i(wr_hi),
        .wr_addr_i(cur_addr), .din_i(din_s), .clr_i(clr_all), .regs_o(regs_o)
    );

    vsg_scan_shift #(.NREGS(NREGS), .NCNT(NCNT), .REG_W(REG_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .ld_i(scan_ld), .use_cnt_i(scan_cnt),
        .idx_i(scan_idx), .run_i(scan_run), .regs_i(regs_o), .cnt_i(cnt_scan_i),
        .scan_o(scan_o)
    );

    assign freeze_o = halt | ~regs_o[CLK_EN_BIT];
endmodule

// File: rtl/vsg_prog_chk.sv
// Property checker for the programming port, bound to every instance.
module vsg_prog_chk
    import vsg_pkg::*;
#(
    parameter int NREGS = 19,
    parameter int NCNT  = 3,
    parameter int REG_W = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   load_rise,
    input logic [ADDR_W-1:0]      cur_addr,
    input logic                   clr_all,
    input logic [NREGS*REG_W-1:0] regs,
    input logic                   freeze,
    input logic                   restart
);
    logic [NREGS*REG_W-1:0] prev_q;
    logic                   clr_d;
    logic [NREGS-1:0]       chg;
    addr_kind_e             kind;

    // Previous register image and delayed clear for change counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            clr_d  <= 1'b0;
        end else begin
            prev_q <= regs;
            clr_d  <= clr_all;
        end
    end

    // Per-register change flags and current address kind.
    always_comb begin
        for (int k = 0; k < NREGS; k++)
            chg[k] = regs[k*REG_W +: REG_W] != prev_q[k*REG_W +: REG_W];
        kind = classify(cur_addr, ADDR_W'(NREGS), ADDR_W'(NCNT));
    end

    assert_regs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_rise |=> $stable(regs));

    assert_single_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_d |-> $countones(chg) <= 1);

    assert_restart_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart);

    assert_restart_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> ($past(cur_addr) == A_RESTART_LO || $past(cur_addr) == A_RESTART_HI));

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> regs == '0);

    assert_halt_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
        kind_halts(kind) |-> freeze);
endmodule

bind vsg_prog_port vsg_prog_chk #(.NREGS(NREGS), .NCNT(NCNT), .REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .load_rise(load_rise), .cur_addr(cur_addr),
    .clr_all(clr_all), .regs(regs_o), .freeze(freeze_o), .restart(restart_o)
);

// File: tb/sim_vsg_prog_port.sv
`timescale 1ns/1ps
module sim_vsg_prog_port;
    localparam int NREGS = 19;
    localparam int REG_W = 12;
    localparam int NCNT  = 3;
    localparam int NONE  = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b1;
    logic sel_data = 1'b0;
    logic sel_hi = 1'b0;
    logic [7:0] din = 8'h00;
    logic [NCNT*REG_W-1:0] cnt = {12'h0F0, 12'hA5C, 12'h123};
    logic [NREGS*REG_W-1:0] regs;
    logic freeze, restart, scan;
    int n_tests = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    vsg_prog_port u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load), .sel_data_i(sel_data),
        .sel_hi_i(sel_hi), .din_i(din), .cnt_scan_i(cnt), .regs_o(regs),
        .freeze_o(freeze), .restart_o(restart), .scan_o(scan)
    );

    typedef struct packed {
        logic [1:0]  ctl;   // {sel_data, sel_hi}
        logic [7:0]  din;
        logic [4:0]  chk;   // register to check, NONE = skip
        logic [11:0] exp;
        logic        frz;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 8'd5,    5'd31, 12'h000, 1'b1, 4'd2},  // R2 manual address
        '{2'b10, 8'hAB,   5'd5,  12'h0AB, 1'b1, 4'd2},
        '{2'b11, 8'h3B,   5'd5,  12'hBAB, 1'b1, 4'd2},  // upper nibble ignored
        '{2'b01, 8'd17,   5'd31, 12'h000, 1'b1, 4'd4},  // R4 auto entry
        '{2'b10, 8'h11,   5'd17, 12'h011, 1'b1, 4'd4},
        '{2'b11, 8'h02,   5'd17, 12'h211, 1'b1, 4'd4},
        '{2'b10, 8'h22,   5'd18, 12'h022, 1'b1, 4'd4},
        '{2'b11, 8'h03,   5'd18, 12'h322, 1'b1, 4'd5},  // R5 wraps to 17
        '{2'b10, 8'h44,   5'd17, 12'h244, 1'b1, 4'd5},
        '{2'b11, 8'h05,   5'd17, 12'h544, 1'b1, 4'd5},
        '{2'b01, 8'd18,   5'd31, 12'h000, 1'b1, 4'd5},  // start at 18
        '{2'b10, 8'h66,   5'd18, 12'h366, 1'b1, 4'd5},
        '{2'b11, 8'h07,   5'd18, 12'h766, 1'b1, 4'd5},
        '{2'b10, 8'h77,   5'd18, 12'h777, 1'b1, 4'd5},  // R5 stays on 18
        '{2'b00, 8'd0,    5'd31, 12'h000, 1'b1, 4'd4},  // R4 exit
        '{2'b10, 8'h00,   5'd0,  12'h000, 1'b1, 4'd3},
        '{2'b11, 8'h04,   5'd0,  12'h400, 1'b0, 4'd12}, // R12 clock enable
        '{2'b10, 8'h55,   5'd0,  12'h455, 1'b0, 4'd4},  // manual: no advance
        '{2'b00, 8'd19,   5'd31, 12'h000, 1'b0, 4'd6},  // R6 unused
        '{2'b10, 8'hFF,   5'd5,  12'hBAB, 1'b0, 4'd6},
        '{2'b11, 8'h0F,   5'd18, 12'h777, 1'b0, 4'd6},
        '{2'b00, 8'd63,   5'd31, 12'h000, 1'b0, 4'd6},
        '{2'b10, 8'h12,   5'd0,  12'h455, 1'b0, 4'd6}
    };

    function automatic logic [11:0] get_reg(input int k);
        return regs[k*REG_W +: REG_W];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One load cycle: fall takes the controls, rise commits; returns in the
    // first sampling slot after the rise has taken effect.
    task automatic do_load(input logic [1:0] ctl, input logic [7:0] d);
        @(negedge clk);
        sel_data = ctl[1];
        sel_hi = ctl[0];
        din = d;
        repeat (2) @(negedge clk);
        load = 1'b0;
        repeat (4) @(negedge clk);
        load = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic scan_check(input string req, input logic [11:0] word);
        for (int k = 0; k < 14; k++) begin
            if (k > 0) @(negedge clk);
            check(req, scan, word[(k > 11) ? 11 : k]);
        end
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic all_zero;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        all_zero = 1'b1;
        for (int k = 0; k < NREGS; k++) if (get_reg(k) != 12'h0) all_zero = 1'b0;
        check("R1 regs", all_zero, 1'b1);
        check("R1 freeze", freeze, 1'b1);
        check("R1 restart", restart, 1'b0);
        check("R1 scan", scan, 1'b0);

        // Table walk: R2 R3 R4 R5 R6 R12
        for (int i = 0; i < NV; i++) begin
            string tag;
            do_load(VECS[i].ctl, VECS[i].din);
            tag = $sformatf("R%0d row%0d", VECS[i].req, i);
            if (VECS[i].chk != 5'(NONE)) check(tag, get_reg(int'(VECS[i].chk)), VECS[i].exp);
            check(tag, freeze, VECS[i].frz);
        end

        // R10 register scan of register 5
        do_load(2'b00, 8'd37);
        check("R10 freeze", freeze, 1'b1);
        scan_check("R10 bits", 12'hBAB);

        // R11 counter scan of counter 1
        do_load(2'b00, 8'd52);
        scan_check("R11 bits", 12'hA5C);

        // Leaving a scan address gives no restart (R7)
        do_load(2'b00, 8'd5);
        check("R7 no pulse", restart, 1'b0);
        check("R12 resume", freeze, 1'b0);

        // R9: auto mode on a restart vector, data loads do nothing
        do_load(2'b01, 8'd54);
        check("R7 restart freeze", freeze, 1'b1);
        do_load(2'b10, 8'h99);
        check("R9 lo", get_reg(5), 12'hBAB);
        do_load(2'b11, 8'h09);
        check("R9 hi", get_reg(5), 12'hBAB);
        check("R9 no advance", freeze, 1'b1);
        check("R7 regs kept", get_reg(17), 12'h544);

        // R7: leaving the restart vector pulses once
        do_load(2'b00, 8'd2);
        check("R7 pulse", restart, 1'b1);
        check("R7 released", freeze, 1'b0);
        @(negedge clk);
        check("R7 one cycle", restart, 1'b0);

        // R8 clear vector
        do_load(2'b00, 8'd23);
        all_zero = 1'b1;
        for (int k = 0; k < NREGS; k++) if (get_reg(k) != 12'h0) all_zero = 1'b0;
        check("R8 zeroed", all_zero, 1'b1);
        check("R8 freeze", freeze, 1'b1);
        do_load(2'b00, 8'd1);
        check("R12 bit10 low", freeze, 1'b1);
        check("R7 no pulse after clear", restart, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule